// File: doc/BRIEF.md
# Bus Target Claim Logic

This block is the target-side front end of one port of a split-transaction bus bridge. It watches the shared bus for a new transaction. When `bus_frame` rises it captures the address and command. On the following clock it captures the requester attributes. It then checks whether the address lies inside its fixed window and whether the command is one it serves. On a hit it claims the transaction by driving `bus_devsel` at the single fast-decode slot. In the same cycle it loads an internal request packet for the upstream side of the bridge.

A burst read is never served immediately. It is always answered with a deferred (split) response. A write is held through its data beats until the initiator ends it. The beat address may run past a 4 KB page without the block disconnecting. The no-snoop and relaxed-ordering hints only pass through into fixed bits of the packet attribute field. The block itself keeps strict ordering. It holds one pending packet, which drains through a valid/ready handshake.

Top module: `tcl_target_claim`

## Requirements
- R1: With the address captured at the rising edge where `bus_frame` is first seen high, `bus_devsel` rises at the second rising edge after it and never at the first.
- R2: Only addresses in the inclusive window WIN_BASE..WIN_LIMIT (default 0x0001_0000..0x0003_FFFF) are claimed. Outside it `bus_devsel` stays low and no packet is produced.
- R3: Only command codes 0x7 (single write), 0xF (burst write) and 0xE (burst read) are claimed. Any other code is left unclaimed.
- R4: `pkt_attr` bit 1 carries the no-snoop input and bit 2 carries the relaxed-ordering input. Bits 0 and 3 are zero. Neither hint changes claim timing or ordering.
- R5: A claimed burst read asserts `bus_split_rsp` together with `bus_devsel` for exactly one cycle. Both are then low, and `pkt_split` is 1. For writes `pkt_split` is 0.
- R6: For a claimed write, `bus_devsel` stays high until an edge that samples `bus_data_valid` high with `bus_frame` low. It is low from the next cycle.
- R7: `tgt_beat_addr` starts at the transaction address and advances by 8 at every edge that samples a data beat. It crosses 4 KB page boundaries with `bus_devsel` still high.
- R8: Each claim produces exactly one packet holding the start address, command, attributes and byte count. `pkt_valid` and the packet fields hold steady until `pkt_ready` is high.
- R9: A hit whose claim edge finds a pending packet with `pkt_ready` low is not claimed. If `pkt_ready` is high at that edge, the old packet drains and the new one loads at that same edge.
- R10: After reset, `bus_devsel`, `bus_split_rsp` and `pkt_valid` are low and `tgt_beat_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_frame | input | 1 | Initiator holds a transaction open |
| bus_addr | input | AW | Transaction address, address phase |
| bus_cmd | input | 4 | Command code, address phase |
| bus_no_snoop | input | 1 | No-snoop hint, attribute phase |
| bus_relaxed | input | 1 | Relaxed-ordering hint, attribute phase |
| bus_byte_cnt | input | BC_W | Requested byte count, attribute phase |
| bus_data_valid | input | 1 | Initiator data beat present |
| bus_devsel | output | 1 | Target claims the transaction |
| bus_split_rsp | output | 1 | Deferred response signalled |
| tgt_beat_addr | output | AW | Address of the current data beat |
| pkt_valid | output | 1 | Request packet pending |
| pkt_ready | input | 1 | Upstream accepts the packet |
| pkt_addr | output | AW | Packet start address |
| pkt_cmd | output | 4 | Packet command |
| pkt_attr | output | 4 | Packet attribute field |
| pkt_byte_cnt | output | BC_W | Packet byte count |
| pkt_split | output | 1 | Packet belongs to a deferred read |

## Verification
Two functions can land on the same clock edge: draining the one pending packet and loading the packet of a new claim. The bench stalls `pkt_ready` so that a packet is left pending. It then raises `pkt_ready` only during the decode cycle of a following hit. A correct result shows `bus_devsel` claiming on time, with `pkt_valid` unbroken and carrying the new address. An earlier hit made while `pkt_ready` stays low must leave the bus unclaimed and the old packet untouched.

// File: rtl/tcl_pkg.sv
package tcl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ATTR,
        ST_DECODE,
        ST_DATA,
        ST_SPLIT
    } tcl_state_e;

    localparam int CMD_W  = 4;
    localparam int ATTR_W = 4;
    localparam int NS_BIT = 1;
    localparam int RO_BIT = 2;

    localparam logic [CMD_W-1:0] CMD_MEM_WR   = 4'h7;
    localparam logic [CMD_W-1:0] CMD_BURST_RD = 4'hE;
    localparam logic [CMD_W-1:0] CMD_BURST_WR = 4'hF;

endpackage

// File: rtl/tcl_window_decode.sv
module tcl_window_decode
    import tcl_pkg::*;
#(
    parameter int              AW        = 32,
    parameter logic [AW-1:0]   WIN_BASE  = '0,
    parameter logic [AW-1:0]   WIN_LIMIT = '1
) (
    input  logic [AW-1:0]    addr,
    input  logic [CMD_W-1:0] cmd,
    output logic             hit,
    output logic             is_burst_rd
);
    logic in_window;
    logic cmd_served;

    always_comb begin
        in_window = (addr >= WIN_BASE) && (addr <= WIN_LIMIT);
        unique case (cmd)
            CMD_MEM_WR, CMD_BURST_WR, CMD_BURST_RD: cmd_served = 1'b1;
            default:                                cmd_served = 1'b0;
        endcase
        hit         = in_window && cmd_served;
        is_burst_rd = (cmd == CMD_BURST_RD);
    end
endmodule

// File: rtl/tcl_attr_map.sv
module tcl_attr_map
    import tcl_pkg::*;
(
    input  logic              no_snoop,
    input  logic              relaxed,
    output logic [ATTR_W-1:0] attr
);
    for (genvar b = 0; b < ATTR_W; b++) begin : g_bit
        if (b == NS_BIT) begin : g_ns
            assign attr[b] = no_snoop;
        end else if (b == RO_BIT) begin : g_ro
            assign attr[b] = relaxed;
        end else begin : g_zero
            assign attr[b] = 1'b0;
        end
    end
endmodule

// File: rtl/tcl_beat_step.sv
module tcl_beat_step #(
    parameter int AW         = 32,
    parameter int BEAT_BYTES = 8
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STEP = AW'(BEAT_BYTES);

    assign nxt = cur + STEP;
endmodule

// File: rtl/tcl_target_claim.sv
module tcl_target_claim
    import tcl_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            BC_W       = 12,
    parameter int            BEAT_BYTES = 8,
    parameter logic [AW-1:0] WIN_BASE   = 32'h0001_0000,
    parameter logic [AW-1:0] WIN_LIMIT  = 32'h0003_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_frame,
    input  logic [AW-1:0]     bus_addr,
    input  logic [3:0]        bus_cmd,
    input  logic              bus_no_snoop,
    input  logic              bus_relaxed,
    input  logic [BC_W-1:0]   bus_byte_cnt,
    input  logic              bus_data_valid,
    output logic              bus_devsel,
    output logic              bus_split_rsp,
    output logic [AW-1:0]     tgt_beat_addr,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [AW-1:0]     pkt_addr,
    output logic [3:0]        pkt_cmd,
    output logic [3:0]        pkt_attr,
    output logic [BC_W-1:0]   pkt_byte_cnt,
    output logic              pkt_split
);
    typedef struct packed {
        tcl_state_e          fsm;
        logic                frame_prev;
        logic [AW-1:0]       addr;
        logic [CMD_W-1:0]    cmd;
        logic                ns;
        logic                ro;
        logic [BC_W-1:0]     bytes;
        logic                devsel;
        logic                split;
        logic [AW-1:0]       beat_addr;
        logic                pv;
        logic [AW-1:0]       p_addr;
        logic [CMD_W-1:0]    p_cmd;
        logic [ATTR_W-1:0]   p_attr;
        logic [BC_W-1:0]     p_bytes;
        logic                p_split;
    } tcl_regs_t;

    tcl_regs_t s_d, s_q;

    logic              win_hit;
    logic              burst_rd;
    logic [ATTR_W-1:0] mapped_attr;
    logic [AW-1:0]     beat_next;
    logic              slot_free;

    tcl_window_decode #(
        .AW        (AW),
        .WIN_BASE  (WIN_BASE),
        .WIN_LIMIT (WIN_LIMIT)
    ) decode_i (
        .addr        (s_q.addr),
        .cmd         (s_q.cmd),
        .hit         (win_hit),
        .is_burst_rd (burst_rd)
    );

    tcl_attr_map attr_i (
        .no_snoop (s_q.ns),
        .relaxed  (s_q.ro),
        .attr     (mapped_attr)
    );

    tcl_beat_step #(
        .AW         (AW),
        .BEAT_BYTES (BEAT_BYTES)
    ) step_i (
        .cur (s_q.beat_addr),
        .nxt (beat_next)
    );

    assign slot_free = !s_q.pv || pkt_ready;

    always_comb begin
        s_d            = s_q;
        s_d.frame_prev = bus_frame;

        if (s_q.pv && pkt_ready) begin
            s_d.pv = 1'b0;
        end

        unique case (s_q.fsm)
            ST_IDLE: begin
                if (bus_frame && !s_q.frame_prev) begin
                    s_d.addr = bus_addr;
                    s_d.cmd  = bus_cmd;
                    s_d.fsm  = ST_ATTR;
                end
            end
            ST_ATTR: begin
                s_d.ns    = bus_no_snoop;
                s_d.ro    = bus_relaxed;
                s_d.bytes = bus_byte_cnt;
                s_d.fsm   = ST_DECODE;
            end
            ST_DECODE: begin
                if (win_hit && slot_free) begin
                    s_d.devsel    = 1'b1;
                    s_d.pv        = 1'b1;
                    s_d.p_addr    = s_q.addr;
                    s_d.p_cmd     = s_q.cmd;
                    s_d.p_attr    = mapped_attr;
                    s_d.p_bytes   = s_q.bytes;
                    s_d.p_split   = burst_rd;
                    s_d.beat_addr = s_q.addr;
                    if (burst_rd) begin
                        s_d.split = 1'b1;
                        s_d.fsm   = ST_SPLIT;
                    end else begin
                        s_d.fsm   = ST_DATA;
                    end
                end else begin
                    s_d.fsm = ST_IDLE;
                end
            end
            ST_DATA: begin
                if (bus_data_valid) begin
                    s_d.beat_addr = beat_next;
                    if (!bus_frame) begin
                        s_d.devsel = 1'b0;
                        s_d.fsm    = ST_IDLE;
                    end
                end
            end
            ST_SPLIT: begin
                s_d.devsel = 1'b0;
                s_d.split  = 1'b0;
                s_d.fsm    = ST_IDLE;
            end
            default: begin
                s_d.fsm = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_devsel    = s_q.devsel;
    assign bus_split_rsp = s_q.split;
    assign tgt_beat_addr = s_q.beat_addr;
    assign pkt_valid     = s_q.pv;
    assign pkt_addr      = s_q.p_addr;
    assign pkt_cmd       = s_q.p_cmd;
    assign pkt_attr      = s_q.p_attr;
    assign pkt_byte_cnt  = s_q.p_bytes;
    assign pkt_split     = s_q.p_split;
endmodule

// File: rtl/tcl_target_claim_chk.sv
module tcl_target_claim_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_frame,
    input logic          bus_data_valid,
    input logic          bus_devsel,
    input logic          bus_split_rsp,
    input logic          pkt_valid,
    input logic          pkt_ready,
    input logic [AW-1:0] pkt_addr
);
    AST_CLAIM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_devsel) |-> ($past(bus_frame, 3) && !$past(bus_frame, 4))); // R1

    AST_CLAIM_LOADS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_devsel) |-> pkt_valid); // R8

    AST_SPLIT_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_split_rsp |-> bus_devsel); // R5

    AST_SPLIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_split_rsp |=> (!bus_split_rsp && !bus_devsel)); // R5

    AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_devsel && !bus_split_rsp && bus_data_valid && !bus_frame) |=> !bus_devsel); // R6

    AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_addr))); // R8

    AST_NO_CLAIM_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> !$rose(bus_devsel)); // R9
endmodule

bind tcl_target_claim tcl_target_claim_chk #(.AW(AW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_frame      (bus_frame),
    .bus_data_valid (bus_data_valid),
    .bus_devsel     (bus_devsel),
    .bus_split_rsp  (bus_split_rsp),
    .pkt_valid      (pkt_valid),
    .pkt_ready      (pkt_ready),
    .pkt_addr       (pkt_addr)
);

// File: tb/tcl_target_claim_tb_top.sv
`timescale 1ns/1ps
module tcl_target_claim_tb_top;
    localparam int          AW    = 32;
    localparam int          BC_W  = 12;
    localparam logic [31:0] BASE  = 32'h0001_0000;
    localparam logic [31:0] LIMIT = 32'h0003_FFFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_frame = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [3:0]      bus_cmd = '0;
    logic            bus_no_snoop = 1'b0;
    logic            bus_relaxed = 1'b0;
    logic [BC_W-1:0] bus_byte_cnt = '0;
    logic            bus_data_valid = 1'b0;
    logic            pkt_ready = 1'b1;
    logic            bus_devsel, bus_split_rsp, pkt_valid, pkt_split;
    logic [AW-1:0]   tgt_beat_addr, pkt_addr;
    logic [3:0]      pkt_cmd, pkt_attr;
    logic [BC_W-1:0] pkt_byte_cnt;

    int checks = 0;
    int errors = 0;
    int claims = 0;
    int handshakes = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tcl_target_claim dut_i (
        .clk(clk), .rst_n(rst_n), .bus_frame(bus_frame), .bus_addr(bus_addr),
        .bus_cmd(bus_cmd), .bus_no_snoop(bus_no_snoop), .bus_relaxed(bus_relaxed),
        .bus_byte_cnt(bus_byte_cnt), .bus_data_valid(bus_data_valid),
        .bus_devsel(bus_devsel), .bus_split_rsp(bus_split_rsp),
        .tgt_beat_addr(tgt_beat_addr), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_addr(pkt_addr), .pkt_cmd(pkt_cmd), .pkt_attr(pkt_attr),
        .pkt_byte_cnt(pkt_byte_cnt), .pkt_split(pkt_split)
    );

    always @(posedge clk) begin
        if (rst_n && pkt_valid && pkt_ready) handshakes++;
    end

    function automatic bit exp_hit(input logic [31:0] a, input logic [3:0] c);
        return (a >= BASE) && (a <= LIMIT) && (c == 4'h7 || c == 4'hE || c == 4'hF);
    endfunction

    function automatic logic [3:0] exp_attr(input logic ns, input logic ro);
        return {1'b0, ro, ns, 1'b0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_txn(input logic [31:0] a, input logic [3:0] c, input logic ns,
                          input logic ro, input logic [11:0] bc, input int beats,
                          input bit slot_busy, input bit ready_at_decode);
        bit claim;
        bit rd;
        logic [31:0] held_addr;
        claim = exp_hit(a, c) && !slot_busy;
        rd = (c == 4'hE);
        held_addr = pkt_addr;
        @(negedge clk);
        bus_frame = 1'b1; bus_addr = a; bus_cmd = c;
        @(negedge clk);
        bus_no_snoop = ns; bus_relaxed = ro; bus_byte_cnt = bc;
        bus_addr = ~a; bus_cmd = ~c;
        @(negedge clk);
        bus_no_snoop = ~ns; bus_relaxed = ~ro; bus_byte_cnt = ~bc;
        check("R1 no claim one clock after address", bus_devsel, 0);
        if (ready_at_decode) pkt_ready = 1'b1;
        @(negedge clk);
        check("R1/R2/R3 claim at second clock", bus_devsel, claim);
        if (claim) begin
            claims++;
            check("R5 split flag", bus_split_rsp, rd);
            check("R8 packet valid", pkt_valid, 1);
            check("R8 packet addr", pkt_addr, a);
            check("R8 packet cmd", pkt_cmd, c);
            check("R4 packet attr", pkt_attr, exp_attr(ns, ro));
            check("R8 packet bytes", pkt_byte_cnt, bc);
            check("R5 packet split", pkt_split, rd);
        end else if (slot_busy) begin
            check("R9 pending packet kept", pkt_addr, held_addr);
            check("R9 pending packet valid", pkt_valid, 1);
        end
        if (!claim) begin
            bus_frame = 1'b0;
            @(negedge clk);
            check("R2/R3 unclaimed stays low", bus_devsel, 0);
            return;
        end
        if (rd) begin
            bus_frame = 1'b0;
            @(negedge clk);
            check("R5 released after split", {bus_devsel, bus_split_rsp}, 0);
            return;
        end
        for (int i = 0; i < beats; i++) begin
            bus_data_valid = 1'b1;
            bus_frame = (i != beats - 1);
            @(negedge clk);
            if (i != beats - 1) check("R6/R7 held through beats", bus_devsel, 1);
        end
        bus_data_valid = 1'b0; bus_frame = 1'b0;
        check("R6 released after last beat", bus_devsel, 0);
        check("R7 beat address", tgt_beat_addr, a + 32'(beats * 8));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R10 reset devsel", bus_devsel, 0);
        check("R10 reset split", bus_split_rsp, 0);
        check("R10 reset pkt_valid", pkt_valid, 0);
        check("R10 reset beat addr", tgt_beat_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_txn(32'h0001_0FF0, 4'hF, 1'b1, 1'b0, 12'h050, 10, 0, 0); // R7 page cross
        do_txn(32'h0002_7FF8, 4'h7, 1'b0, 1'b1, 12'h008, 3, 0, 0);  // R7
        do_txn(BASE,          4'hF, 1'b1, 1'b1, 12'h100, 2, 0, 0);  // R2 base edge
        do_txn(LIMIT,         4'h7, 1'b0, 1'b0, 12'h004, 1, 0, 0);  // R2 limit edge
        do_txn(BASE - 1,      4'hF, 1'b0, 1'b0, 12'h010, 1, 0, 0);  // R2 below
        do_txn(LIMIT + 1,     4'hF, 1'b0, 1'b0, 12'h010, 1, 0, 0);  // R2 above
        do_txn(32'h0002_0000, 4'h6, 1'b0, 1'b0, 12'h010, 1, 0, 0);  // R3 unserved
        do_txn(32'h0002_0000, 4'hE, 1'b1, 1'b1, 12'h080, 1, 0, 0);  // R5 burst read

        pkt_ready = 1'b0;                                            // R9
        do_txn(32'h0001_2000, 4'hF, 1'b0, 1'b1, 12'h020, 2, 0, 0);
        do_txn(32'h0001_3000, 4'hF, 1'b1, 1'b0, 12'h020, 2, 1, 0);
        do_txn(32'h0001_4000, 4'hE, 1'b0, 1'b0, 12'h040, 1, 0, 1);
        @(negedge clk);
        check("R9 new packet drained", pkt_valid, 0);

        for (int n = 0; n < 300; n++) begin
            logic [3:0] cmds [6];
            logic [31:0] ra;
            cmds = '{4'h3, 4'h6, 4'h7, 4'hE, 4'hF, 4'hF};
            ra = 32'h0000_F000 + (($urandom % 32'h0003_2000) & 32'hFFFF_FFF8);
            if (n % 5 == 0) ra = {ra[31:12], 12'hFE0};
            do_txn(ra, cmds[$urandom % 6], 1'($urandom), 1'($urandom),
                   12'($urandom), 1 + int'($urandom % 40), 0, 0);
            @(negedge clk);
        end

        repeat (2) @(negedge clk);
        check("R8 one packet per claim", handshakes, claims);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule